// File: doc/BRIEF.md
# Port-Mapped I/O Select Decoder with Latched Ports

This block is the glue between an 8-bit processor bus and a pair of simple peripheral ports. It checks a seven-bit field of the I/O address against a fixed block number. On a match it turns the three lowest address bits into one of eight active-low select lines. The selects are produced only while exactly one of the two active-low I/O strobes (read or write) is asserted. Other devices on the bus can use the eight selects directly.

Two of the selects are used inside the block. The output port is a transparent latch. While its write select is active, the device-side outputs follow the write data bus. When the select goes away they hold the last byte, so a display driven from them stays steady between writes. The input port passes device data towards the processor through a bus driver. That driver is enabled only during a read of its own port number. The tri-state bus is represented by a data vector plus a drive-enable, and the data reads zero whenever the drive-enable is low. If both strobes are low together, the cycle is treated as illegal: no select, no latch update and no drive. A registered flag reports the clash on the next clock edge.

Top module: `pio_decode_latch`

## Requirements
- R1: A port is selected only when address bits 9 down to 3 equal 1001010 (ports at 0x250 to 0x257). With any other value in that field, all eight `sel_n` lines stay high. Bits 15 to 10 are ignored.
- R2: When selection is allowed, `sel_n[k]` goes low for k equal to address bits 2 to 0, and no other line is low. At most one `sel_n` line is ever low.
- R3: Selects are asserted only while exactly one of `ior_n` and `iow_n` is low. When both strobes are high, all `sel_n` lines are high.
- R4: The output port is port 0 (address 0x250). While `iow_n` is low and port 0 is selected, `dev_out` equals `bus_wdata` in the same cycle and follows any change in it.
- R5: When the write select of port 0 is inactive, `dev_out` holds its last value. Changes of `bus_wdata`, reads, and writes to other ports leave it unchanged.
- R6: The input port is port 1 (address 0x251). `bus_rdata_oe` is high, and `bus_rdata` equals `dev_in`, only while `ior_n` is low and port 1 is selected. At all other times `bus_rdata_oe` is low and `bus_rdata` is zero.
- R7: When both strobes are low together, no select is asserted, `dev_out` is not updated and `bus_rdata_oe` stays low. `rw_clash` is high after the next rising clock edge and low after the first edge at which the clash has ended.
- R8: While `rst` is high, `dev_out` is cleared to zero. After a clock edge with `rst` high, `rw_clash` is zero.
- R9: A write to the input port's number does not change `dev_out` or `bus_rdata_oe`. A read of the output port's number does not change `dev_out` or `bus_rdata_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the clash flag |
| rst | input | 1 | Active-high reset; synchronous for the flag, level-clear for the output latch |
| addr | input | 16 | I/O address bus |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| bus_wdata | input | 8 | Data bus value written by the processor |
| bus_rdata | output | 8 | Data driven toward the processor, zero when not driven |
| bus_rdata_oe | output | 1 | Bus drive enable of the input port |
| dev_in | input | 8 | Device data presented to the input port |
| dev_out | output | 8 | Latched device-side outputs of the output port |
| sel_n | output | 8 | Decoded active-low port selects |
| rw_clash | output | 1 | Registered flag: both strobes were low at the last edge |

## Verification
Everything except the clash flag is combinational from the address, strobes and data. The bench therefore changes inputs on the falling clock edge and samples those outputs a few nanoseconds later, in the same half period and before the next rising edge. The clash flag passes through one register. It is sampled just after the rising edge that follows the stimulus, and again after the edge that follows its removal. The latch-hold checks sample `dev_out` after the write select has dropped and a new `bus_wdata` value has been applied. This shows the held value is independent of the bus.

// File: rtl/pio_pkg.sv
package pio_pkg;

    // Kind of bus cycle, derived from the two active-low I/O strobes
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_CLASH = 2'd3
    } bus_cycle_e;

    // Default block number compared against the upper address field
    localparam logic [6:0] DEFAULT_BLOCK_ID = 7'b1001010;

    function automatic bus_cycle_e classify_cycle(input logic rd_n, input logic wr_n);
        bus_cycle_e c;
        unique case ({rd_n, wr_n})
            2'b11:   c = CYC_IDLE;
            2'b01:   c = CYC_READ;
            2'b10:   c = CYC_WRITE;
            default: c = CYC_CLASH;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pio_block_match.sv
module pio_block_match #(
    parameter int ADDR_W   = 16,
    parameter int MATCH_LO = 3,
    parameter int MATCH_W  = 7,
    parameter logic [MATCH_W-1:0] BLOCK_ID = 7'b1001010
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int MATCH_HI = MATCH_LO + MATCH_W - 1;

    logic [MATCH_W-1:0] field;
    logic               unused_addr_bits;

    assign field = addr[MATCH_HI:MATCH_LO];
    assign hit   = (field == BLOCK_ID);

    // Bits outside the compared field take no part in the match
    assign unused_addr_bits = ^{addr[ADDR_W-1:MATCH_HI+1], addr[MATCH_LO-1:0]};

endmodule

// File: rtl/pio_sel_decoder.sv
module pio_sel_decoder #(
    parameter int SEL_W = 3
) (
    input  logic                   en_hi,
    input  logic                   en_a_n,
    input  logic                   en_b_n,
    input  logic [SEL_W-1:0]       sel,
    output logic [(1<<SEL_W)-1:0]  y_n
);
    localparam int NUM_OUT = 1 << SEL_W;

    logic enabled;
    assign enabled = en_hi & ~en_a_n & ~en_b_n;

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        assign y_n[k] = ~(enabled && (sel == SEL_W'(k)));
    end

endmodule

// File: rtl/pio_port_latch.sv
module pio_port_latch #(
    parameter int W = 8
) (
    input  logic         rst,
    input  logic         le,
    input  logic         oe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         q_oe
);
    logic [W-1:0] held;

    // Level-sensitive storage: transparent while le is high
    always_latch begin
        if (rst)
            held <= '0;
        else if (le)
            held <= d;
    end

    assign q    = oe ? held : '0;
    assign q_oe = oe;

endmodule

// File: rtl/pio_decode_latch.sv
module pio_decode_latch
    import pio_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 3,
    parameter int MATCH_LO = 3,
    parameter int MATCH_W  = 7,
    parameter logic [MATCH_W-1:0] BLOCK_ID = DEFAULT_BLOCK_ID,
    parameter int OUT_PORT = 0,
    parameter int IN_PORT  = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ior_n,
    input  logic                    iow_n,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_rdata_oe,
    input  logic [DATA_W-1:0]       dev_in,
    output logic [DATA_W-1:0]       dev_out,
    output logic [(1<<SEL_W)-1:0]   sel_n,
    output logic                    rw_clash
);
    localparam int NUM_PORTS = 1 << SEL_W;

    bus_cycle_e cyc;
    logic       blk_hit;
    logic       out_le;
    logic       in_drive;
    logic       out_oe_unused;

    assign cyc = classify_cycle(ior_n, iow_n);

    pio_block_match #(
        .ADDR_W   (ADDR_W),
        .MATCH_LO (MATCH_LO),
        .MATCH_W  (MATCH_W),
        .BLOCK_ID (BLOCK_ID)
    ) u_match (
        .addr (addr),
        .hit  (blk_hit)
    );

    // Active-high enable from the block compare; one active-low enable
    // needs a strobe, the other is withdrawn on a read/write clash.
    pio_sel_decoder #(
        .SEL_W (SEL_W)
    ) u_dec (
        .en_hi  (blk_hit),
        .en_a_n (cyc == CYC_IDLE),
        .en_b_n (cyc == CYC_CLASH),
        .sel    (addr[SEL_W-1:0]),
        .y_n    (sel_n)
    );

    assign out_le   = ~sel_n[OUT_PORT] && (cyc == CYC_WRITE);
    assign in_drive = ~sel_n[IN_PORT]  && (cyc == CYC_READ);

    // Output port: bus to device, output side always enabled
    pio_port_latch #(
        .W (DATA_W)
    ) u_out_port (
        .rst  (rst),
        .le   (out_le),
        .oe   (1'b1),
        .d    (bus_wdata),
        .q    (dev_out),
        .q_oe (out_oe_unused)
    );

    // Input port: device to bus, transparent, drive gated by the read select
    pio_port_latch #(
        .W (DATA_W)
    ) u_in_port (
        .rst  (1'b0),
        .le   (1'b1),
        .oe   (in_drive),
        .d    (dev_in),
        .q    (bus_rdata),
        .q_oe (bus_rdata_oe)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rw_clash <= 1'b0;
        else
            rw_clash <= (cyc == CYC_CLASH);
    end

    if (OUT_PORT >= NUM_PORTS || IN_PORT >= NUM_PORTS) begin : g_bad_port
        initial $error("port index outside decoder range");
    end

endmodule

// File: rtl/pio_decode_latch_chk.sv
module pio_decode_latch_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 3,
    parameter int MATCH_LO = 3,
    parameter int MATCH_W  = 7,
    parameter logic [MATCH_W-1:0] BLOCK_ID = 7'b1001010,
    parameter int OUT_PORT = 0,
    parameter int IN_PORT  = 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [ADDR_W-1:0]       addr,
    input logic                    ior_n,
    input logic                    iow_n,
    input logic [DATA_W-1:0]       bus_wdata,
    input logic [DATA_W-1:0]       bus_rdata,
    input logic                    bus_rdata_oe,
    input logic [DATA_W-1:0]       dev_in,
    input logic [DATA_W-1:0]       dev_out,
    input logic [(1<<SEL_W)-1:0]   sel_n,
    input logic                    rw_clash
);
    localparam int MATCH_HI = MATCH_LO + MATCH_W - 1;

    logic in_block;
    logic wr_out;
    logic rd_in;
    logic unused_chk_bits;

    assign in_block = (addr[MATCH_HI:MATCH_LO] == BLOCK_ID);
    assign wr_out   = in_block && !iow_n && ior_n && (addr[SEL_W-1:0] == SEL_W'(OUT_PORT));
    assign rd_in    = in_block && !ior_n && iow_n && (addr[SEL_W-1:0] == SEL_W'(IN_PORT));
    assign unused_chk_bits = ^addr;

    // R1
    property block_mismatch_quiet_p;
        @(posedge clk) disable iff (rst) !in_block |-> (&sel_n);
    endproperty
    block_mismatch_chk: assert property (block_mismatch_quiet_p);

    // R2
    property sel_onehot_p;
        @(posedge clk) disable iff (rst) $onehot0(~sel_n);
    endproperty
    sel_onehot_chk: assert property (sel_onehot_p);

    // R3
    property idle_no_sel_p;
        @(posedge clk) disable iff (rst) (ior_n && iow_n) |-> (&sel_n);
    endproperty
    idle_no_sel_chk: assert property (idle_no_sel_p);

    // R4
    property latch_follow_p;
        @(posedge clk) disable iff (rst) wr_out |-> (dev_out == bus_wdata);
    endproperty
    latch_follow_chk: assert property (latch_follow_p);

    // R5
    property latch_hold_p;
        @(posedge clk) disable iff (rst) (!wr_out && !$past(wr_out)) |-> $stable(dev_out);
    endproperty
    latch_hold_chk: assert property (latch_hold_p);

    // R6
    property read_drive_p;
        @(posedge clk) disable iff (rst)
            (bus_rdata_oe == rd_in) && (bus_rdata_oe ? (bus_rdata == dev_in) : (bus_rdata == '0));
    endproperty
    read_drive_chk: assert property (read_drive_p);

    // R7
    property clash_flag_p;
        @(posedge clk) disable iff (rst) (!ior_n && !iow_n) |=> rw_clash;
    endproperty
    clash_flag_chk: assert property (clash_flag_p);

    // R7
    property clash_no_drive_p;
        @(posedge clk) disable iff (rst) (!ior_n && !iow_n) |-> (!bus_rdata_oe && (&sel_n));
    endproperty
    clash_no_drive_chk: assert property (clash_no_drive_p);

endmodule

bind pio_decode_latch pio_decode_latch_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SEL_W    (SEL_W),
    .MATCH_LO (MATCH_LO),
    .MATCH_W  (MATCH_W),
    .BLOCK_ID (BLOCK_ID),
    .OUT_PORT (OUT_PORT),
    .IN_PORT  (IN_PORT)
) u_chk (.*);

// File: tb/tb_pio_decode_latch.sv
module tb_pio_decode_latch;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        ior_n;
    logic        iow_n;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_oe;
    logic [7:0]  dev_in;
    logic [7:0]  dev_out;
    logic [7:0]  sel_n;
    logic        rw_clash;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pio_decode_latch dut (
        .clk          (clk),
        .rst          (rst),
        .addr         (addr),
        .ior_n        (ior_n),
        .iow_n        (iow_n),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_rdata_oe (bus_rdata_oe),
        .dev_in       (dev_in),
        .dev_out      (dev_out),
        .sel_n        (sel_n),
        .rw_clash     (rw_clash)
    );

    // {addr, ior_n, iow_n, wdata, dev_in, exp sel_n, exp oe, exp rdata, exp dev_out}
    localparam int NV = 12;
    localparam logic [58:0] VEC [NV] = '{
        {16'h0250, 1'b1, 1'b0, 8'hA5, 8'h3C, 8'hFE, 1'b0, 8'h00, 8'hA5}, // R4 write port 0
        {16'h0250, 1'b1, 1'b1, 8'h00, 8'h3C, 8'hFF, 1'b0, 8'h00, 8'hA5}, // R3 R5 idle holds
        {16'h0251, 1'b0, 1'b1, 8'h00, 8'h3C, 8'hFD, 1'b1, 8'h3C, 8'hA5}, // R6 read port 1
        {16'h0251, 1'b0, 1'b1, 8'h00, 8'h5A, 8'hFD, 1'b1, 8'h5A, 8'hA5}, // R6 follows dev_in
        {16'h0258, 1'b0, 1'b1, 8'h00, 8'h5A, 8'hFF, 1'b0, 8'h00, 8'hA5}, // R1 A3 mismatch
        {16'h0257, 1'b1, 1'b0, 8'hFF, 8'h5A, 8'h7F, 1'b0, 8'h00, 8'hA5}, // R2 R5 port 7
        {16'h0250, 1'b0, 1'b0, 8'h11, 8'h5A, 8'hFF, 1'b0, 8'h00, 8'hA5}, // R7 clash
        {16'hFE50, 1'b1, 1'b0, 8'h3C, 8'h5A, 8'hFE, 1'b0, 8'h00, 8'h3C}, // R1 upper bits ignored
        {16'h0050, 1'b1, 1'b0, 8'h77, 8'h5A, 8'hFF, 1'b0, 8'h00, 8'h3C}, // R1 A9 mismatch
        {16'h0253, 1'b0, 1'b1, 8'h00, 8'h5A, 8'hF7, 1'b0, 8'h00, 8'h3C}, // R2 port 3 read
        {16'h0251, 1'b1, 1'b0, 8'h99, 8'h5A, 8'hFD, 1'b0, 8'h00, 8'h3C}, // R9 write input port
        {16'h0250, 1'b0, 1'b1, 8'h66, 8'h5A, 8'hFE, 1'b0, 8'h00, 8'h3C}  // R9 read output port
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic r, input logic w,
                         input logic [7:0] wd, input logic [7:0] di);
        @(negedge clk);
        addr = a; ior_n = r; iow_n = w; bus_wdata = wd; dev_in = di;
        #2;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; addr = '0; ior_n = 1'b1; iow_n = 1'b1; bus_wdata = 8'hEE; dev_in = '0;
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        check("R8 dev_out in reset", 32'(dev_out), 32'h00);
        check("R8 rw_clash in reset", 32'(rw_clash), 32'h0);
        check("R3 sel_n idle in reset", 32'(sel_n), 32'hFF);
        @(negedge clk);
        rst = 1'b0;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][58:43], VEC[i][42], VEC[i][41], VEC[i][40:33], VEC[i][32:25]);
            check($sformatf("R1/R2/R3 sel_n vec %0d", i), 32'(sel_n), 32'(VEC[i][24:17]));
            check($sformatf("R6 oe vec %0d", i), 32'(bus_rdata_oe), 32'(VEC[i][16]));
            check($sformatf("R6 rdata vec %0d", i), 32'(bus_rdata), 32'(VEC[i][15:8]));
            check($sformatf("R4/R5 dev_out vec %0d", i), 32'(dev_out), 32'(VEC[i][7:0]));
        end

        // R4 transparency: data changes while the write select stays active
        drive(16'h0250, 1'b1, 1'b0, 8'h12, 8'h00);
        check("R4 follow first", 32'(dev_out), 32'h12);
        drive(16'h0250, 1'b1, 1'b0, 8'h34, 8'h00);
        check("R4 follow second", 32'(dev_out), 32'h34);
        // R5 hold after the strobe rises, bus changes
        drive(16'h0250, 1'b1, 1'b1, 8'hC3, 8'h00);
        check("R5 hold after write", 32'(dev_out), 32'h34);
        drive(16'h0250, 1'b1, 1'b1, 8'h0F, 8'h00);
        check("R5 hold bus change", 32'(dev_out), 32'h34);

        // R7 clash flag timing
        drive(16'h0251, 1'b0, 1'b0, 8'hAA, 8'h81);
        check("R7 no drive on clash", 32'(bus_rdata_oe), 32'h0);
        check("R7 dev_out kept on clash", 32'(dev_out), 32'h34);
        @(posedge clk); #1;
        check("R7 rw_clash set", 32'(rw_clash), 32'h1);
        drive(16'h0251, 1'b0, 1'b1, 8'hAA, 8'h81);
        check("R7 read after clash", 32'(bus_rdata), 32'h81);
        @(posedge clk); #1;
        check("R7 rw_clash cleared", 32'(rw_clash), 32'h0);

        // R8 reset clears the held byte and the flag
        drive(16'h0250, 1'b0, 1'b0, 8'h00, 8'h00);
        @(posedge clk); #1;
        check("R7 rw_clash before reset", 32'(rw_clash), 32'h1);
        @(negedge clk);
        rst = 1'b1; ior_n = 1'b1; iow_n = 1'b1;
        #2;
        check("R8 dev_out cleared", 32'(dev_out), 32'h00);
        @(posedge clk); #1;
        check("R8 rw_clash cleared", 32'(rw_clash), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        drive(16'h0250, 1'b1, 1'b1, 8'h55, 8'h00);
        check("R5 hold after reset", 32'(dev_out), 32'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule